// File: doc/BRIEF.md
# Two-Step Vernier Phase Measurement Logic

This block contains the counting and combining logic of a two-step time-to-digital converter. It measures the time between a reference clock edge and a divided feedback clock edge. Whichever of the two rises first starts a measurement. The block counts rising edges of the slow oscillator until the other edge rises, which gives the coarse result. It then counts rising edges of the fast oscillator until an external phase-coincidence indication reports that the fast oscillator has caught up with the slow one, which gives the fine result. The resolution of one coarse count is the slow oscillator period. The resolution of one fine count is the slow period minus the fast period.

The two counts are scaled by separate programmable weights and added into one signed 16-bit phase word for the loop filter. The sign says which edge came first, and a separate flag repeats that information. All inputs are sampled in one system clock domain through two-flop capture stages. The ring oscillators are outside the block.

Top module: `vernierTdc`

## Requirements
- R1: After reset, `phaseValid`, `leadFlag`, `coarseOvf` and `fineOvf` are 0, and `phaseWord` is 0.
- R2: The coarse count equals the number of rising `slowOsc` edges between the starting edge and the rising edge of the other input.
- R3: The fine count equals the number of rising `fastOsc` edges from the stopping edge until `coincide` is seen high.
- R4: The magnitude of the result is `coarseCount*coarseWeight + fineCount*fineWeight`, with both weights unsigned 8-bit values.
- R5: When `refIn` rises first, `leadFlag` is 1 and `phaseWord` is the positive magnitude. When `divIn` rises first, `leadFlag` is 0 and `phaseWord` is the two's-complement negative of the magnitude.
- R6: `phaseValid` is high for exactly one system clock per measurement, after the fine step ends. `phaseWord` and `leadFlag` hold their values until the next result.
- R7: Each 8-bit counter stops at 255 instead of wrapping. An extra edge at 255 sets its overflow output (`coarseOvf` or `fineOvf`), which stays set until the next measurement starts.
- R8: A magnitude above 32767 is clamped to 32767 before the sign is applied.
- R9: After a result, no new measurement starts until `refIn` has been seen low. Edges on `divIn`, `slowOsc`, `fastOsc` and `coincide` while `refIn` stays high produce no `phaseValid` and leave `phaseWord` unchanged.
- R10: Both counters and both overflow flags clear when a measurement starts, so a result does not depend on any earlier measurement.
- R11: When `refIn` and `divIn` rise in the same sampled cycle, the coarse count is 0, `leadFlag` is 1, and the fine step follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refIn | input | 1 | Reference clock |
| divIn | input | 1 | Divided feedback clock |
| slowOsc | input | 1 | Slow oscillator output |
| fastOsc | input | 1 | Fast oscillator output |
| coincide | input | 1 | High when the fast oscillator phase has caught up with the slow one |
| coarseWeight | input | 8 | Weight applied to the coarse count |
| fineWeight | input | 8 | Weight applied to the fine count |
| phaseWord | output | 16 | Signed, weighted phase difference |
| phaseValid | output | 1 | One-cycle strobe marking a new `phaseWord` |
| leadFlag | output | 1 | 1 when the reference edge came first |
| coarseOvf | output | 1 | Coarse counter went past its maximum |
| fineOvf | output | 1 | Fine counter went past its maximum |

## Verification
The hardest condition to reach from the ports is the post-result wait. It only shows up when `refIn` is held high after a result while the other inputs keep toggling. The bench reaches it by finishing one measurement, then sending a second divided edge, more oscillator pulses and a coincidence pulse with `refIn` still high. It checks that no strobe appears and that the word does not change. It then lowers `refIn` and confirms that a fresh measurement starts from cleared counters. The counter-saturation cases are reached by sending 300 oscillator pulses in one step. The weights are chosen so that the clamp in R8 and the both-edges-at-once case in R11 each get their own run.

// File: rtl/vernierPkg.sv
package vernierPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2,
    ST_DONE   = 2'd3
  } tdcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;  // start of measurement: clear counters and flags
    logic leadVal;   // with clearCnt: reference edge came first
    logic cntSlow;   // coarse step active
    logic cntFast;   // fine step active
    logic latch;     // fine step finished: register the result
  } tdcStrobe_t;

  // bit positions on the sampled input bus
  localparam int IDX_REF  = 0;
  localparam int IDX_DIV  = 1;
  localparam int IDX_SLOW = 2;
  localparam int IDX_FAST = 3;
  localparam int IDX_COIN = 4;
  localparam int NUM_IN   = 5;

endpackage

// File: rtl/vernierEdgeDet.sv
module vernierEdgeDet #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] sigIn,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);

  logic [N-1:0] stage1;
  logic [N-1:0] stage2;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= sigIn[i];
        stage2[i] <= stage1[i];
      end
    end
    assign level[i] = stage1[i];
    assign rise[i]  = stage1[i] & ~stage2[i];
  end

endmodule

// File: rtl/vernierCtrl.sv
module vernierCtrl
  import vernierPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refRise,
  input  logic       divRise,
  input  logic       refLvl,
  input  logic       coincideLvl,
  output tdcStrobe_t strobe
);

  tdcState_t state;
  tdcState_t nextState;
  logic      refFirst;
  logic      stopEdge;

  always_comb begin
    nextState = state;
    strobe    = '0;
    stopEdge  = refFirst ? divRise : refRise;
    case (state)
      ST_IDLE: begin
        if (refRise || divRise) begin
          strobe.clearCnt = 1'b1;
          strobe.leadVal  = refRise;
          nextState       = (refRise && divRise) ? ST_FINE : ST_COARSE;
        end
      end
      ST_COARSE: begin
        if (stopEdge) nextState = ST_FINE;
        else          strobe.cntSlow = 1'b1;
      end
      ST_FINE: begin
        if (coincideLvl) begin
          strobe.latch = 1'b1;
          nextState    = ST_DONE;
        end else begin
          strobe.cntFast = 1'b1;
        end
      end
      ST_DONE: begin
        if (!refLvl) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      refFirst <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.clearCnt) refFirst <= refRise;
    end
  end

  // R9: stay in the result state while the reference is still high
  a_r9_hold_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && refLvl) |=> (state == ST_DONE));

  // R6: a result is taken only once per measurement
  a_r6_latch_done: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> (state == ST_DONE && !strobe.latch));

  // R11: both edges together skip the coarse step
  a_r11_skip_coarse: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && refRise && divRise) |=> (state == ST_FINE));

endmodule

// File: rtl/vernierDatapath.sv
module vernierDatapath
  import vernierPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WGT_W = 8,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tdcStrobe_t              strobe,
  input  logic                    slowRise,
  input  logic                    fastRise,
  input  logic [WGT_W-1:0]        coarseWeight,
  input  logic [WGT_W-1:0]        fineWeight,
  output logic signed [OUT_W-1:0] phaseWord,
  output logic                    phaseValid,
  output logic                    leadFlag,
  output logic                    coarseOvf,
  output logic                    fineOvf
);

  localparam int PROD_W = CNT_W + WGT_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int MAG_W  = OUT_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SUM_W-1:0] MAG_MAX = SUM_W'((64'd1 << MAG_W) - 64'd1);

  logic [CNT_W-1:0]  coarseCnt;
  logic [CNT_W-1:0]  fineCnt;
  logic              leadPend;
  logic [PROD_W-1:0] coarseProd;
  logic [PROD_W-1:0] fineProd;
  logic [SUM_W-1:0]  sumRaw;
  logic [MAG_W-1:0]  magClamp;
  logic [OUT_W-1:0]  magExt;
  logic [OUT_W-1:0]  signedWord;

  // saturating counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseCnt <= '0;
      fineCnt   <= '0;
      coarseOvf <= 1'b0;
      fineOvf   <= 1'b0;
      leadPend  <= 1'b0;
    end else if (strobe.clearCnt) begin
      coarseCnt <= '0;
      fineCnt   <= '0;
      coarseOvf <= 1'b0;
      fineOvf   <= 1'b0;
      leadPend  <= strobe.leadVal;
    end else begin
      if (strobe.cntSlow && slowRise) begin
        if (coarseCnt == CNT_MAX) coarseOvf <= 1'b1;
        else                      coarseCnt <= coarseCnt + 1'b1;
      end
      if (strobe.cntFast && fastRise) begin
        if (fineCnt == CNT_MAX) fineOvf <= 1'b1;
        else                    fineCnt <= fineCnt + 1'b1;
      end
    end
  end

  // weighting and combining
  always_comb begin
    coarseProd = PROD_W'(coarseCnt) * PROD_W'(coarseWeight);
    fineProd   = PROD_W'(fineCnt) * PROD_W'(fineWeight);
    sumRaw     = SUM_W'(coarseProd) + SUM_W'(fineProd);
    magClamp   = (sumRaw > MAG_MAX) ? MAG_MAX[MAG_W-1:0] : sumRaw[MAG_W-1:0];
    magExt     = {1'b0, magClamp};
    signedWord = leadPend ? magExt : (~magExt + 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseWord  <= '0;
      phaseValid <= 1'b0;
      leadFlag   <= 1'b0;
    end else begin
      phaseValid <= strobe.latch;
      if (strobe.latch) begin
        phaseWord <= signedWord;
        leadFlag  <= leadPend;
      end
    end
  end

  // R7: a full counter stays full until the next start
  a_r7_coarse_sat: assert property (@(posedge clk) disable iff (!rstN)
    (coarseCnt == CNT_MAX && !strobe.clearCnt) |=> (coarseCnt == CNT_MAX));

  a_r7_fine_sat: assert property (@(posedge clk) disable iff (!rstN)
    (fineCnt == CNT_MAX && !strobe.clearCnt) |=> (fineCnt == CNT_MAX));

  // R6: strobe is a single-cycle pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    phaseValid |=> !phaseValid);

  // R5: a reference-first result is never negative
  a_r5_sign: assert property (@(posedge clk) disable iff (!rstN)
    (phaseValid && leadFlag) |-> !phaseWord[OUT_W-1]);

  // R10: a start leaves both counters empty
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCnt |=> (coarseCnt == '0 && fineCnt == '0 && !coarseOvf && !fineOvf));

  // R6: result holds between strobes
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid |-> $stable(phaseWord) || $past(strobe.latch));

endmodule

// File: rtl/vernierTdc.sv
module vernierTdc
  import vernierPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WGT_W = 8,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    refIn,
  input  logic                    divIn,
  input  logic                    slowOsc,
  input  logic                    fastOsc,
  input  logic                    coincide,
  input  logic [WGT_W-1:0]        coarseWeight,
  input  logic [WGT_W-1:0]        fineWeight,
  output logic signed [OUT_W-1:0] phaseWord,
  output logic                    phaseValid,
  output logic                    leadFlag,
  output logic                    coarseOvf,
  output logic                    fineOvf
);

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] inLvl;
  logic [NUM_IN-1:0] inRise;
  tdcStrobe_t        strobe;

  always_comb begin
    rawIn           = '0;
    rawIn[IDX_REF]  = refIn;
    rawIn[IDX_DIV]  = divIn;
    rawIn[IDX_SLOW] = slowOsc;
    rawIn[IDX_FAST] = fastOsc;
    rawIn[IDX_COIN] = coincide;
  end

  vernierEdgeDet #(.N(NUM_IN)) edge_i (
    .clk   (clk),
    .rstN  (rstN),
    .sigIn (rawIn),
    .level (inLvl),
    .rise  (inRise)
  );

  vernierCtrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .refRise     (inRise[IDX_REF]),
    .divRise     (inRise[IDX_DIV]),
    .refLvl      (inLvl[IDX_REF]),
    .coincideLvl (inLvl[IDX_COIN]),
    .strobe      (strobe)
  );

  vernierDatapath #(
    .CNT_W (CNT_W),
    .WGT_W (WGT_W),
    .OUT_W (OUT_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .slowRise     (inRise[IDX_SLOW]),
    .fastRise     (inRise[IDX_FAST]),
    .coarseWeight (coarseWeight),
    .fineWeight   (fineWeight),
    .phaseWord    (phaseWord),
    .phaseValid   (phaseValid),
    .leadFlag     (leadFlag),
    .coarseOvf    (coarseOvf),
    .fineOvf      (fineOvf)
  );

endmodule

// File: tb/vernierTdc_tb_top.sv
module vernierTdc_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refIn = 1'b0, divIn = 1'b0, slowOsc = 1'b0, fastOsc = 1'b0, coincide = 1'b0;
  logic [7:0]  coarseWeight = '0, fineWeight = '0;
  logic signed [15:0] phaseWord;
  logic        phaseValid, leadFlag, coarseOvf, fineOvf;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vernierTdc dut_i (
    .clk(clk), .rstN(rstN), .refIn(refIn), .divIn(divIn), .slowOsc(slowOsc),
    .fastOsc(fastOsc), .coincide(coincide), .coarseWeight(coarseWeight),
    .fineWeight(fineWeight), .phaseWord(phaseWord), .phaseValid(phaseValid),
    .leadFlag(leadFlag), .coarseOvf(coarseOvf), .fineOvf(fineOvf)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic slowPulses(input int n);
    for (int i = 0; i < n; i++) begin
      slowOsc = 1'b1; tick(3); slowOsc = 1'b0; tick(3);
    end
  endtask

  task automatic fastPulses(input int n);
    for (int i = 0; i < n; i++) begin
      fastOsc = 1'b1; tick(2); fastOsc = 1'b0; tick(2);
    end
  endtask

  function automatic int expWord(input int nS, input int nF, input int cw, input int fw, input bit lead);
    int c, f, m;
    c = (nS > 255) ? 255 : nS;
    f = (nF > 255) ? 255 : nF;
    m = c * cw + f * fw;
    if (m > 32767) m = 32767;
    return lead ? m : -m;
  endfunction

  // waits for the strobe; returns cycles waited (-1 on timeout)
  task automatic waitValid(output int seen);
    seen = -1;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (phaseValid) begin seen = i; break; end
    end
  endtask

  // full measurement: mode 0 ref first, 1 div first, 2 both together
  task automatic measure(input string req, input int mode, input int nS, input int nF,
                         input int cw, input int fw);
    int seen;
    bit lead;
    lead = (mode != 1);
    coarseWeight = 8'(cw); fineWeight = 8'(fw);
    if (mode == 0) refIn = 1'b1;
    else if (mode == 1) divIn = 1'b1;
    else begin refIn = 1'b1; divIn = 1'b1; end
    tick(3);
    if (mode != 2) begin
      slowPulses(nS);
      if (mode == 0) divIn = 1'b1; else refIn = 1'b1;
      tick(3);
    end
    fastPulses(nF);
    coincide = 1'b1;
    waitValid(seen);
    check({req, " strobe seen"}, int'(seen >= 0), 1);
    check({req, " word"}, int'(phaseWord), expWord((mode == 2) ? 0 : nS, nF, cw, fw, lead));
    check({req, " leadFlag R5"}, int'(leadFlag), int'(lead));
    check({req, " coarseOvf R7"}, int'(coarseOvf), int'(nS > 255 && mode != 2));
    check({req, " fineOvf R7"}, int'(fineOvf), int'(nF > 255));
    tick(1);
    check({req, " strobe width R6"}, int'(phaseValid), 0);
    coincide = 1'b0; refIn = 1'b0; divIn = 1'b0;
    tick(4);
  endtask

  task automatic testReset();
    check("R1 valid", int'(phaseValid), 0);
    check("R1 word", int'(phaseWord), 0);
    check("R1 lead", int'(leadFlag), 0);
    check("R1 ovf", int'(coarseOvf | fineOvf), 0);
  endtask

  // R9: edges while ref stays high after a result are ignored
  task automatic testHoldWhileRefHigh();
    int seen;
    int held;
    coarseWeight = 8'd3; fineWeight = 8'd1;
    refIn = 1'b1; tick(3); slowPulses(4); divIn = 1'b1; tick(3);
    fastPulses(2); coincide = 1'b1;
    waitValid(seen);
    check("R9 first result", int'(phaseWord), 14);
    held = int'(phaseWord);
    coincide = 1'b0; divIn = 1'b0; tick(4);
    divIn = 1'b1; tick(3); slowPulses(2); fastPulses(3);
    coincide = 1'b1; tick(3); coincide = 1'b0; divIn = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      if (phaseValid) seen = 1;
    end
    check("R9 no strobe while ref high", seen, 0);
    check("R9 word unchanged", int'(phaseWord), held);
    refIn = 1'b0; tick(4);
    measure("R9 R10 after ref low", 1, 2, 5, 3, 1);
  endtask

  initial begin
    tick(3);
    testReset();
    rstN = 1'b1;
    tick(2);
    measure("R2 coarse only", 0, 7, 3, 1, 0);
    measure("R3 fine only", 0, 5, 9, 0, 1);
    measure("R4 weighted sum", 0, 6, 4, 20, 3);
    measure("R5 div first", 1, 5, 2, 10, 7);
    measure("R7 coarse saturation", 0, 300, 1, 1, 1);
    measure("R7 fine saturation", 1, 1, 300, 0, 1);
    measure("R8 magnitude clamp", 0, 200, 200, 255, 255);
    measure("R8 negative clamp", 1, 200, 10, 255, 10);
    measure("R10 small after large", 0, 1, 1, 2, 1);
    measure("R11 edges together", 2, 0, 6, 50, 2);
    testHoldWhileRefHigh();
    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule